// File: doc/BRIEF.md
# Triggered Delay Down-Counter Channel

This block is one timer channel in one-shot delay mode. Software loads a reload value into a data register and enables the channel with a start strobe. The channel then waits for a start trigger. A trigger is either a software start strobe or a chosen edge on an input pin. The pin path has a synchronizer and a noise filter that software can switch on or off. Once a trigger is accepted, the channel copies the reload value into its counter on the next count tick. After that it counts down by one on every further tick. The ticks come from a clock-enable pulse made by an external prescaler.

When the counter reaches zero, the channel raises a one-cycle interrupt pulse. The counter then stays at zero until a new trigger restarts it. A stop strobe clears the enable flag and freezes the counter at its current value. The data register can be rewritten at any time, and a new value takes effect only at the next trigger load. The count can be read at any time.

Top module: `dly_cnt_channel`

## Requirements
- R1: After a synchronous active-low reset, `run_flag` is 0, `cnt_q` and `data_q` are 0000H, and `irq` is 0.
- R2: A `start_req` pulse without `stop_req` sets `run_flag` to 1 at the next clock edge, and it also counts as a start trigger in that same cycle.
- R3: After an accepted trigger, the first `tick_en` cycle loads `data_q` into `cnt_q`.
- R4: Each later tick lowers `cnt_q` by one. On the edge where `cnt_q` becomes 0000H, `irq` goes high for exactly one cycle. Further ticks leave `cnt_q` at 0000H with `irq` low.
- R5: A load of 0000H raises `irq` for one cycle on the load tick, and the counter then stays at zero.
- R6: A `stop_req` pulse clears `run_flag` at the next edge, and it wins over a `start_req` in the same cycle. While `run_flag` is 0 and no start is requested, `cnt_q` keeps its value whatever the ticks do.
- R7: A `data_wr` pulse stores `data_in` in `data_q` at the next edge, in any state. The count in progress is not changed, and the new value is used at the next trigger load.
- R8: While the counter is decrementing, start triggers from software and from the pin are ignored.
- R9: `edge_fall`=0 selects a rising pin edge (0 to 1) as the trigger, and `edge_fall`=1 selects a falling edge (1 to 0). The other edge does not trigger.
- R10: With `filt_on`=1, the synchronized pin level is accepted only after two equal consecutive samples, so a pulse of one clock is rejected. With `filt_on`=0, a pulse of one clock is a valid edge.
- R11: Pin edges are ignored while `run_flag` is 0.
- R12: `cnt_q` changes only in cycles where `tick_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count tick from the prescaler, one clock wide |
| pin_in | input | 1 | Asynchronous trigger pin |
| filt_on | input | 1 | 1 turns on the two-sample noise filter |
| edge_fall | input | 1 | 0 selects the rising edge, 1 selects the falling edge |
| start_req | input | 1 | Software start strobe (self-clearing, reads back as 0) |
| stop_req | input | 1 | Software stop strobe (self-clearing, reads back as 0) |
| data_wr | input | 1 | Write strobe for the data register |
| data_in | input | 16 | Write data for the data register |
| data_q | output | 16 | Data register readback |
| cnt_q | output | 16 | Count register readback |
| run_flag | output | 1 | Channel enable status |
| irq | output | 1 | One-cycle expiry interrupt |

## Verification
The bench sweeps the reload values 0 to 12 and checks the count after every tick. This catches a load of the wrong value, an interrupt that comes one tick early or late, a reload after expiry instead of parking at zero, and a load of zero that never raises the interrupt. It restarts the channel while it is counting, by software and by the pin, to catch a design that reloads on a trigger it should ignore. It also rewrites the data register during a count, to catch a design that applies the new value at once. After a stop, it applies ticks and a pin edge to expose a counter that keeps running or a trigger that gets through while the channel is disabled. Finally, it applies edges of both polarities and one-clock glitches with the filter on and off, to catch a swapped polarity or a filter that lets glitches through.

// File: rtl/dc_pkg.sv
// Package dc_pkg
// Shared types of the delay down-counter channel.
// Assumes: nothing beyond a single clock domain for the consumers.
package dc_pkg;
    // Phase of the counting engine
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,   // idle or parked, waiting for a trigger
        PH_ARMED = 2'd1,   // trigger seen, load on next tick
        PH_RUN   = 2'd2    // decrementing
    } dc_phase_e;
endpackage

// File: rtl/dc_pin_sync.sv
// Module dc_pin_sync
// Brings an asynchronous pin into the clock domain through a flop chain.
// Assumes: STAGES >= 2; reset value of the chain is 0.
module dc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_async};
        end
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dc_noise_filter.sv
// Module dc_noise_filter
// Optional glitch filter: when enabled, the output level follows the input
// only after the input has held the same value on two consecutive clocks.
// When disabled, the output is the input delayed by one clock.
// Assumes: input is already synchronous.
module dc_noise_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic level_in,
    output logic level_out
);
    logic prev_q;
    logic lvl_q;

    // Remember the previous synchronous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_in;
        end
    end

    // Update the filtered level when allowed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (!filt_en || (level_in == prev_q)) begin
            lvl_q <= level_in;
        end
    end

    assign level_out = lvl_q;
endmodule

// File: rtl/dc_edge_sel.sv
// Module dc_edge_sel
// Produces a one-cycle pulse on the selected edge of a clean level.
// Assumes: level is synchronous and glitch-free.
module dc_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_sel,
    input  logic level,
    output logic edge_pulse
);
    logic level_d;

    // Delay the level by one clock for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
        end else begin
            level_d <= level;
        end
    end

    // Pick rising or falling transition
    always_comb begin
        if (fall_sel) begin
            edge_pulse = level_d & ~level;
        end else begin
            edge_pulse = level & ~level_d;
        end
    end
endmodule

// File: rtl/dc_down_counter.sv
// Module dc_down_counter
// Counting engine. An accepted trigger arms the engine, the next tick loads
// the reload value, and every later tick decrements. On reaching zero, a
// one-cycle expiry pulse is registered and the engine parks at zero.
// Triggers are ignored while decrementing. Stop returns to idle and
// freezes the count.
// Assumes: trig is already qualified by the enable logic; stop overrides.
module dc_down_counter
    import dc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig,
    input  logic             stop,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    dc_phase_e        phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             exp_q, exp_d;

    // Next-state logic of the engine
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        exp_d   = 1'b0;
        if (stop) begin
            phase_d = PH_WAIT;
        end else begin
            case (phase_q)
                PH_WAIT: begin
                    if (trig) begin
                        phase_d = PH_ARMED;
                    end
                end
                PH_ARMED: begin
                    if (tick) begin
                        cnt_d = load_val;
                        if (load_val == ZERO) begin
                            exp_d   = 1'b1;
                            phase_d = PH_WAIT;
                        end else begin
                            phase_d = PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    if (tick) begin
                        cnt_d = cnt_q - ONE;
                        if (cnt_q == ONE) begin
                            exp_d   = 1'b1;
                            phase_d = PH_WAIT;
                        end
                    end
                end
                default: begin
                    phase_d = PH_WAIT;
                end
            endcase
        end
    end

    // State registers of the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WAIT;
            cnt_q   <= '0;
            exp_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            exp_q   <= exp_d;
        end
    end

    assign cnt    = cnt_q;
    assign expire = exp_q;
endmodule

// File: rtl/dly_cnt_channel.sv
// Module dly_cnt_channel
// One delay-mode timer channel: data register, enable flag, pin trigger
// path (sync, optional filter, edge select) and the counting engine.
// Assumes: tick_en is a one-clock enable from an external prescaler;
// start_req and stop_req are one-clock strobes from a register interface.
module dly_cnt_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             pin_in,
    input  logic             filt_on,
    input  logic             edge_fall,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             data_wr,
    input  logic [CNT_W-1:0] data_in,
    output logic [CNT_W-1:0] data_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_flag,
    output logic             irq
);
    logic             pin_s;
    logic             pin_clean;
    logic             pin_edge;
    logic             trig_ok;
    logic             en_q;
    logic [CNT_W-1:0] data_r;

    // Data register, writable in any state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_r <= '0;
        end else if (data_wr) begin
            data_r <= data_in;
        end
    end

    // Enable flag: stop wins over start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (stop_req) begin
            en_q <= 1'b0;
        end else if (start_req) begin
            en_q <= 1'b1;
        end
    end

    dc_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(pin_in),
        .pin_sync (pin_s)
    );

    dc_noise_filter u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt_en  (filt_on),
        .level_in (pin_s),
        .level_out(pin_clean)
    );

    dc_edge_sel u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_sel  (edge_fall),
        .level     (pin_clean),
        .edge_pulse(pin_edge)
    );

    // Qualify triggers: software start always, pin edge only when enabled
    always_comb begin
        trig_ok = (start_req | (pin_edge & en_q)) & ~stop_req;
    end

    dc_down_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .trig    (trig_ok),
        .stop    (stop_req),
        .load_val(data_r),
        .cnt     (cnt_q),
        .expire  (irq)
    );

    assign data_q   = data_r;
    assign run_flag = en_q;
endmodule

// File: rtl/dly_cnt_channel_chk.sv
// Module dly_cnt_channel_chk
// Property checker bound to dly_cnt_channel.
module dly_cnt_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             start_req,
    input logic             stop_req,
    input logic             data_wr,
    input logic [CNT_W-1:0] data_in,
    input logic [CNT_W-1:0] data_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             run_flag,
    input logic             irq
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R4
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (cnt_q == '0)); // R4
    AST_START_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n) (start_req && !stop_req) |=> run_flag); // R2
    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n) stop_req |=> !run_flag); // R6
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!run_flag && !start_req) |=> $stable(cnt_q)); // R6
    AST_DATA_STORED: assert property (@(posedge clk) disable iff (!rst_n) data_wr |=> (data_q == $past(data_in))); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick_en |=> $stable(cnt_q)); // R12
endmodule

bind dly_cnt_channel dly_cnt_channel_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .start_req(start_req),
    .stop_req (stop_req),
    .data_wr  (data_wr),
    .data_in  (data_in),
    .data_q   (data_q),
    .cnt_q    (cnt_q),
    .run_flag (run_flag),
    .irq      (irq)
);

// File: tb/dly_cnt_channel_tb.sv
module dly_cnt_channel_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        pin_in = 1'b0;
    logic        filt_on = 1'b0;
    logic        edge_fall = 1'b0;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        data_wr = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] data_q;
    logic [15:0] cnt_q;
    logic        run_flag;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dly_cnt_channel u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .pin_in   (pin_in),
        .filt_on  (filt_on),
        .edge_fall(edge_fall),
        .start_req(start_req),
        .stop_req (stop_req),
        .data_wr  (data_wr),
        .data_in  (data_in),
        .data_q   (data_q),
        .cnt_q    (cnt_q),
        .run_flag (run_flag),
        .irq      (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One tick, then sample after the edge
    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic wr_data(input int v);
        data_in = v[15:0];
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        pin_in = v;
        idle(8);
    endtask

    task automatic glitch();
        pin_in = ~pin_in;
        @(negedge clk);
        pin_in = ~pin_in;
        idle(8);
    endtask

    task automatic run_out();
        for (int i = 0; i < 100; i++) begin
            if (cnt_q == 16'd0) break;
            tick();
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        check("R1 run_flag", run_flag, 0);
        check("R1 cnt_q", cnt_q, 0);
        check("R1 data_q", data_q, 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;
        idle(2);

        // R12: ticks with no trigger do nothing
        tick();
        check("R12 idle tick", cnt_q, 0);

        // Sweep reload values: R2 R3 R4 R5
        for (int d = 0; d <= 12; d++) begin
            wr_data(d);
            check("R7 data write", data_q, d);
            pulse_start();
            check("R2 enable set", run_flag, 1);
            idle(2);
            check("R12 no tick hold", cnt_q, (d == 0) ? 0 : 0);
            tick();
            check("R3 load value", cnt_q, d);
            check("R5 irq on load", irq, (d == 0) ? 1 : 0);
            for (int k = d - 1; k >= 0; k--) begin
                tick();
                check("R4 decrement", cnt_q, k);
                check("R4 irq timing", irq, (k == 0) ? 1 : 0);
            end
            idle(1);
            check("R4 irq single cycle", irq, 0);
            tick();
            tick();
            check("R4 parked at zero", cnt_q, 0);
            check("R4 no repeat irq", irq, 0);
        end

        // R8: retrigger while counting is ignored
        wr_data(20);
        pulse_start();
        tick();
        check("R3 load 20", cnt_q, 20);
        tick();
        pulse_start();
        tick();
        check("R8 sw retrigger ignored", cnt_q, 18);
        set_pin(1'b1);
        tick();
        check("R8 pin retrigger ignored", cnt_q, 17);
        // R7: rewrite data mid-count
        wr_data(5);
        tick();
        check("R7 count unaffected", cnt_q, 16);
        // R6: stop freezes
        pulse_stop();
        check("R6 enable cleared", run_flag, 0);
        tick();
        tick();
        check("R6 count frozen", cnt_q, 16);
        // R11: pin edge while disabled
        set_pin(1'b0);
        set_pin(1'b1);
        tick();
        check("R11 pin ignored when off", cnt_q, 16);
        // R7: new data at next trigger
        pulse_start();
        tick();
        check("R7 new data loaded", cnt_q, 5);
        run_out();
        // R6: stop wins over start
        stop_req = 1'b1;
        start_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        start_req = 1'b0;
        check("R6 stop wins", run_flag, 0);
        tick();
        check("R6 no load after stop", cnt_q, 0);

        // R9 polarity, pin currently 1
        wr_data(9);
        pulse_start();
        tick();
        run_out();
        set_pin(1'b0);
        tick();
        check("R9 falling ignored in rise mode", cnt_q, 0);
        set_pin(1'b1);
        tick();
        check("R9 rising triggers", cnt_q, 9);
        run_out();
        edge_fall = 1'b1;
        idle(2);
        set_pin(1'b0);
        tick();
        check("R9 falling triggers", cnt_q, 9);
        run_out();
        set_pin(1'b1);
        tick();
        check("R9 rising ignored in fall mode", cnt_q, 0);
        set_pin(1'b0);
        tick();
        run_out();

        // R10 filter, rising mode, pin low
        edge_fall = 1'b0;
        filt_on = 1'b1;
        idle(4);
        glitch();
        tick();
        check("R10 glitch rejected", cnt_q, 0);
        pin_in = 1'b1;
        idle(2);
        pin_in = 1'b0;
        idle(8);
        tick();
        check("R10 two-cycle pulse accepted", cnt_q, 9);
        run_out();
        filt_on = 1'b0;
        idle(4);
        glitch();
        tick();
        check("R10 glitch passes unfiltered", cnt_q, 9);
        run_out();
        check("R4 final park", cnt_q, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule